// File: doc/BRIEF.md
# ADC Trigger Delay Sequencer

This block paces an analog-to-digital converter through a sampling sequence. A power-of-two prescaler divides the system clock into a reference tick. A 16-bit counter advances on that tick and returns to zero once it reaches a programmable modulus. Eight trigger outputs, one per sampling slot, each pulse for exactly one clock. Per-slot enable bits mask slots that are not in use.

The block has two pacing modes. In scheduled mode, every enabled slot fires when the counter equals that slot's own delay value. In chained mode, the first enabled slot fires when the counter equals the slot-0 delay. Each later enabled slot fires in the clock after the converter reports completion for the slot before it, and masked slots are skipped. When the last enabled slot has fired and its completion has arrived, a sticky done flag is set. The flag drives the interrupt output when the interrupt is enabled, and software clears it by writing 1.

A single-pass bit and a repeat bit select whether the counter stops at the modulus or keeps repeating the sequence. Configuration writes go into a holding copy. That copy is transferred to the working copy only while the block is idle or at a modulus wrap, so a pass that is in progress always runs with one consistent setting.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset, all trigger outputs and the interrupt output are low.
- R2: The reference tick period is 2^code clocks, where code is control bits [3:0]. Codes 11 to 15 all give 2048 clocks.
- R3: In scheduled mode (control bit 4 = 0), slot i pulses once, for one clock, (d_i+1)*P clocks after the start pulse is sampled. Here d_i is the delay of slot i (register 8+i) and P is the tick period.
- R4: A slot whose bit in the enable register (address 2, bit i for slot i) is 0 never pulses in either mode.
- R5: With the repeat bit (control bit 5) set, the counter wraps from the modulus (address 1) to zero, so the triggers repeat every (modulus+1)*P clocks.
- R6: With the repeat bit clear, the block fires one pass only and then stops. A start pulse that arrives while the block is running is ignored.
- R7: In chained mode (control bit 4 = 1), the lowest enabled slot fires at the slot-0 delay match. Each next higher enabled slot fires one clock after the completion input of the previously fired slot is sampled. Completion inputs of any other slot are ignored.
- R8: The done flag is set one clock after the completion input of the last enabled slot is sampled once that slot has fired. The interrupt output is the flag ANDed with the interrupt enable (control bit 6). Writing 1 to bit 0 of address 3 clears the flag.
- R9: The interrupt enable takes effect on the next clock. A flag set while the enable is 0 keeps the interrupt output low until the enable is written to 1.
- R10: A delay, modulus, enable or mode write made while the block is running takes effect only at the next modulus wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| start | input | 1 | Starts a pass when the block is idle |
| conv_done | input | 8 | Per-slot conversion-complete pulses |
| trig | output | 8 | Per-slot one-clock trigger pulses |
| irq | output | 1 | Sequence-complete interrupt |

## Verification
Every trigger is registered once after its match. A scheduled pulse is therefore first visible (d+1)*P clocks after the edge that samples start. A chained pulse, the done flag and the interrupt are each visible one clock after the completion pulse is sampled. The bench numbers the clock edges and records, at the falling edge, which edge each trigger pulse follows. It compares those numbers exactly with the values computed from these formulas, and it samples the interrupt at the falling edge just before and just after the edge where it is due. Window checks such as repeat counts, masked slots and deferred writes are made a few clocks after the last pulse that can occur, so a late or extra pulse still shows up.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_MOD  = 1;
  localparam int unsigned A_CHEN = 2;
  localparam int unsigned A_STAT = 3;
  localparam int unsigned A_DLY0 = 8;

  localparam int unsigned F_CHAIN = 4;
  localparam int unsigned F_REP   = 5;
  localparam int unsigned F_IE    = 6;

  typedef enum logic {
    PACE_SCHED = 1'b0,
    PACE_CHAIN = 1'b1
  } pace_e;
endpackage

// File: rtl/adc_trig_prescale.sv
module adc_trig_prescale #(
  parameter int unsigned DIV_W  = 11,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [DIV_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    if (code >= CODE_W'(DIV_W)) mask = '1;
    else                        mask = DIV_W'((1 << code) - 1);
  end

  assign tick = run && (&(pre_q | ~mask));

  always_comb begin
    pre_d = pre_q;
    if (clr || !run) pre_d = '0;
    else             pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R2
  ps_div1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && code == '0) |-> tick);
  // R2
  ps_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
endmodule

// File: rtl/adc_trig_modcnt.sv
module adc_trig_modcnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] modv,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_d;

  assign wrap = run && tick && (cnt == modv);

  always_comb begin
    cnt_d = cnt;
    if (clr)              cnt_d = '0;
    else if (wrap)        cnt_d = '0;
    else if (run && tick) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R5
  cnt_le_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= modv);
  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrap) |-> (cnt == '0));
endmodule

// File: rtl/adc_trig_pacer.sv
module adc_trig_pacer #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic               restart,
  input  logic               clear_all,
  input  logic               chain,
  input  logic [NCH-1:0]     en,
  input  logic [NCH*CNT_W-1:0] dly,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [NCH-1:0]     conv_done,
  output logic [NCH-1:0]     trig,
  output logic               seq_done
);
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] fire, match;
  logic           armed_q, armed_d, wait_q, wait_d;
  logic [IW-1:0]  cur_q, cur_d, first_idx, last_idx, nxt_idx;
  logic           any_en, nxt_found;

  always_comb begin
    any_en = 1'b0;
    first_idx = '0;
    last_idx = '0;
    nxt_found = 1'b0;
    nxt_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      match[i] = run && tick && en[i] && (cnt == dly[i*CNT_W +: CNT_W]);
      if (en[i]) begin
        if (!any_en) first_idx = IW'(i);
        any_en = 1'b1;
        last_idx = IW'(i);
        if (!nxt_found && (IW'(i) > cur_q)) begin
          nxt_found = 1'b1;
          nxt_idx = IW'(i);
        end
      end
    end
  end

  always_comb begin
    fire = '0;
    armed_d = armed_q;
    wait_d = wait_q;
    cur_d = cur_q;
    seq_done = 1'b0;
    if (!chain) begin
      fire = match;
      if (wait_q && conv_done[cur_q]) begin
        seq_done = 1'b1;
        wait_d = 1'b0;
      end
      if (any_en && match[last_idx]) begin
        wait_d = 1'b1;
        cur_d = last_idx;
      end
    end else begin
      if (wait_q && conv_done[cur_q]) begin
        if (nxt_found) begin
          fire[nxt_idx] = 1'b1;
          cur_d = nxt_idx;
        end else begin
          seq_done = 1'b1;
          wait_d = 1'b0;
        end
      end else if (armed_q && run && tick && any_en &&
                   (cnt == dly[CNT_W-1:0])) begin
        fire[first_idx] = 1'b1;
        armed_d = 1'b0;
        wait_d = 1'b1;
        cur_d = first_idx;
      end
      if (restart) begin
        armed_d = 1'b1;
        wait_d = 1'b0;
      end
    end
    if (clear_all) begin
      armed_d = 1'b1;
      wait_d = 1'b0;
      cur_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig <= '0;
      armed_q <= 1'b1;
      wait_q <= 1'b0;
      cur_q <= '0;
    end else begin
      trig <= fire;
      armed_q <= armed_d;
      wait_q <= wait_d;
      cur_q <= cur_d;
    end
  end

  // R7
  chain_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chain) |-> $onehot0(trig));
  // R3
  sched_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!chain) && (|trig)) |-> $past(tick));
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_trig_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DIV_W  = 11,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              start,
  input  logic [NCH-1:0]    conv_done,
  output logic [NCH-1:0]    trig,
  output logic              irq
);
  // holding (written) copy
  logic [CODE_W-1:0] h_code, h_code_d;
  logic              h_chain, h_chain_d, h_rep, h_rep_d, ie_q, ie_d;
  logic [CNT_W-1:0]  h_mod, h_mod_d;
  logic [NCH-1:0]    h_en, h_en_d;
  logic [CNT_W-1:0]  h_dly [NCH];
  logic [CNT_W-1:0]  h_dly_d [NCH];
  // working copy
  logic [CODE_W-1:0] a_code;
  logic              a_chain, a_rep;
  logic [CNT_W-1:0]  a_mod;
  logic [NCH-1:0]    a_en;
  logic [CNT_W-1:0]  a_dly [NCH];
  logic [NCH*CNT_W-1:0] a_dly_flat;

  logic run_q, run_d, go, load, tick, wrap, seq_done, flag_q, flag_d;
  logic [CNT_W-1:0] cnt;

  assign go   = start && !run_q;
  assign load = !run_q || wrap;

  always_comb begin
    h_code_d = h_code;
    h_chain_d = h_chain;
    h_rep_d = h_rep;
    ie_d = ie_q;
    h_mod_d = h_mod;
    h_en_d = h_en;
    if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CTRL)) begin
        h_code_d = wr_data[CODE_W-1:0];
        h_chain_d = wr_data[F_CHAIN];
        h_rep_d = wr_data[F_REP];
        ie_d = wr_data[F_IE];
      end
      if (wr_addr == ADDR_W'(A_MOD))  h_mod_d = wr_data;
      if (wr_addr == ADDR_W'(A_CHEN)) h_en_d = wr_data[NCH-1:0];
    end
    for (int i = 0; i < NCH; i++) begin
      h_dly_d[i] = h_dly[i];
      if (wr_en && wr_addr == ADDR_W'(A_DLY0 + i)) h_dly_d[i] = wr_data;
    end
  end

  always_comb begin
    run_d = run_q;
    if (go)                 run_d = 1'b1;
    else if (wrap && !a_rep) run_d = 1'b0;
    flag_d = flag_q;
    if (wr_en && wr_addr == ADDR_W'(A_STAT) && wr_data[0]) flag_d = 1'b0;
    if (seq_done) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_code <= '0;
      h_chain <= PACE_SCHED;
      h_rep <= 1'b0;
      ie_q <= 1'b0;
      h_mod <= '1;
      h_en <= '0;
      for (int i = 0; i < NCH; i++) h_dly[i] <= '0;
      run_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      h_code <= h_code_d;
      h_chain <= h_chain_d;
      h_rep <= h_rep_d;
      ie_q <= ie_d;
      h_mod <= h_mod_d;
      h_en <= h_en_d;
      for (int i = 0; i < NCH; i++) h_dly[i] <= h_dly_d[i];
      run_q <= run_d;
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_code <= '0;
      a_chain <= PACE_SCHED;
      a_rep <= 1'b0;
      a_mod <= '1;
      a_en <= '0;
      for (int i = 0; i < NCH; i++) a_dly[i] <= '0;
    end else if (load) begin
      a_code <= h_code;
      a_chain <= h_chain;
      a_rep <= h_rep;
      a_mod <= h_mod;
      a_en <= h_en;
      for (int i = 0; i < NCH; i++) a_dly[i] <= h_dly[i];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign a_dly_flat[g*CNT_W +: CNT_W] = a_dly[g];
  end

  assign irq = flag_q && ie_q;

  adc_trig_prescale #(.DIV_W(DIV_W), .CODE_W(CODE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .clr(go), .code(a_code), .tick(tick)
  );

  adc_trig_modcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .clr(go), .tick(tick),
    .modv(a_mod), .cnt(cnt), .wrap(wrap)
  );

  adc_trig_pacer #(.NCH(NCH), .CNT_W(CNT_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick), .restart(wrap),
    .clear_all(go), .chain(a_chain), .en(a_en), .dly(a_dly_flat), .cnt(cnt),
    .conv_done(conv_done), .trig(trig), .seq_done(seq_done)
  );

  // R4
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig) |-> ((trig & ~$past(a_en)) == '0));
  // R8
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(|conv_done));
  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !a_rep) |=> !run_q);
endmodule

// File: tb/adc_trig_seq_test.sv
module adc_trig_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        start = 1'b0;
  logic [7:0]  conv_done = '0;
  logic [7:0]  trig;
  logic        irq;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int st = 0;
  int fa [8];
  int la [8];
  int fc [8];
  bit finished = 1'b0;

  adc_trig_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .conv_done(conv_done),
    .trig(trig), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (trig[i]) begin
        if (fc[i] == 0) fa[i] = cyc;
        la[i] = cyc;
        fc[i] = fc[i] + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctrl(input int code, input bit chain,
                                       input bit rep, input bit ie);
    return {9'b0, ie, rep, chain, 4'(code)};
  endfunction

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic go();
    @(posedge clk);
    #1;
    for (int i = 0; i < 8; i++) begin fa[i] = -1; la[i] = -1; fc[i] = 0; end
    @(negedge clk);
    start = 1'b1;
    st = cyc + 1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pulse_done(input int ch);
    @(negedge clk);
    conv_done[ch] = 1'b1;
    @(negedge clk);
    conv_done[ch] = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(trig == 8'h00, "R1 trig after reset", int'(trig), 0);
    chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_sched();
    int c;
    do_reset();
    wr(0, ctrl(0, 0, 0, 1));
    wr(1, 16'd30);
    wr(2, 16'b1011_0101);
    for (int i = 0; i < 8; i++) wr(8 + i, 16'(2 * i + 1));
    go();
    wait_to(st + 25);
    foreach (fa[i]) begin
      if ((8'b1011_0101 >> i) & 1) begin
        chk(fa[i] == st + 2 * i + 2, "R3 scheduled slot time", fa[i] - st, 2 * i + 2);
        chk(fc[i] == 1, "R3 single pulse", fc[i], 1);
      end else begin
        chk(fc[i] == 0, "R4 masked slot silent", fc[i], 0);
      end
    end
    pulse_done(5);
    @(negedge clk);
    chk(irq == 1'b0, "R8 non-last done ignored", int'(irq), 0);
    @(negedge clk);
    c = cyc;
    chk(irq == 1'b0, "R8 irq low before last done", int'(irq), 0);
    conv_done[7] = 1'b1;
    @(negedge clk);
    conv_done[7] = 1'b0;
    chk(irq == 1'b1 && cyc == c + 1, "R8 irq one clock after last done", int'(irq), 1);
    wr(3, 16'h0001);
    chk(irq == 1'b0, "R8 write-one clears flag", int'(irq), 0);
  endtask

  task automatic t_prescale();
    do_reset();
    wr(0, ctrl(2, 0, 0, 0));
    wr(1, 16'd100);
    wr(2, 16'h0001);
    wr(8, 16'd3);
    go();
    wait_to(st + 20);
    chk(fa[0] == st + 16, "R2 divide by 4", fa[0] - st, 16);
    do_reset();
    wr(0, ctrl(15, 0, 0, 0));
    wr(1, 16'd100);
    wr(2, 16'h0001);
    wr(8, 16'd0);
    go();
    wait_to(st + 2055);
    chk(fa[0] == st + 2048, "R2 code 15 saturates at 2048", fa[0] - st, 2048);
  endtask

  task automatic t_repeat();
    do_reset();
    wr(0, ctrl(1, 0, 1, 0));
    wr(1, 16'd4);
    wr(2, 16'h0001);
    wr(8, 16'd1);
    go();
    wait_to(st + 12);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_to(st + 37);
    chk(fc[0] == 4, "R5 repeat count", fc[0], 4);
    chk(la[0] == st + 34, "R5 period (mod+1)*P, R6 start ignored", la[0] - st, 34);
  endtask

  task automatic t_single();
    do_reset();
    wr(0, ctrl(0, 0, 0, 0));
    wr(1, 16'd4);
    wr(2, 16'h0001);
    wr(8, 16'd2);
    go();
    wait_to(st + 30);
    chk(fa[0] == st + 3, "R6 single pass time", fa[0] - st, 3);
    chk(fc[0] == 1, "R6 single pass stops", fc[0], 1);
  endtask

  task automatic t_chain();
    int c;
    do_reset();
    wr(0, ctrl(0, 1, 0, 1));
    wr(1, 16'd200);
    wr(2, 16'b0010_0110);
    wr(8, 16'd3);
    wr(9, 16'd50);
    go();
    wait_to(st + 10);
    chk(fa[1] == st + 4, "R7 first chained slot at slot-0 delay", fa[1] - st, 4);
    pulse_done(2);
    repeat (4) @(negedge clk);
    chk(fc[2] == 0, "R7 done of other slot ignored", fc[2], 0);
    c = cyc;
    conv_done[1] = 1'b1;
    @(negedge clk);
    conv_done[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk(fa[2] == c + 1, "R7 next slot one clock after done", fa[2] - c, 1);
    c = cyc;
    conv_done[2] = 1'b1;
    @(negedge clk);
    conv_done[2] = 1'b0;
    repeat (3) @(negedge clk);
    chk(fa[5] == c + 1, "R7 masked slots skipped", fa[5] - c, 1);
    chk(fc[3] == 0 && fc[4] == 0 && fc[0] == 0, "R4 masked in chain", fc[3] + fc[4] + fc[0], 0);
    chk(fc[1] == 1, "R7 first slot once", fc[1], 1);
    chk(irq == 1'b0, "R8 irq low before last done", int'(irq), 0);
    conv_done[5] = 1'b1;
    @(negedge clk);
    conv_done[5] = 1'b0;
    chk(irq == 1'b1, "R8 chain completion", int'(irq), 1);
  endtask

  task automatic t_irq_enable();
    do_reset();
    wr(0, ctrl(0, 0, 0, 0));
    wr(1, 16'd3);
    wr(2, 16'h0001);
    wr(8, 16'd0);
    go();
    wait_to(st + 4);
    pulse_done(0);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9 masked interrupt", int'(irq), 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = ctrl(0, 0, 0, 1);
    @(negedge clk);
    wr_en = 1'b0;
    chk(irq == 1'b1, "R9 enable exposes pending flag", int'(irq), 1);
  endtask

  task automatic t_defer();
    do_reset();
    wr(0, ctrl(0, 0, 1, 0));
    wr(1, 16'd9);
    wr(2, 16'h0001);
    wr(8, 16'd5);
    go();
    wait_to(st + 2);
    wr(8, 16'd8);
    wait_to(st + 23);
    chk(fa[0] == st + 6, "R10 running pass keeps old delay", fa[0] - st, 6);
    chk(fc[0] == 2 && la[0] == st + 19, "R10 new delay after wrap", la[0] - st, 19);
  endtask

  initial begin
    t_reset();
    t_sched();
    t_prescale();
    t_repeat();
    t_single();
    t_chain();
    t_irq_enable();
    t_defer();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule